// File: doc/BRIEF.md
# Asynchronous Memory-Mapped Register Slave

This block is a small register file inside a fast synchronous device. An external processor reaches it the way it would reach a memory: it drives a chip select, separate active-low read and write strobes, an address and a data bus. None of these signals is related to the internal clock. The nominal external access lasts one 50 MHz period, which is two cycles of the 100 MHz internal clock.

Every strobe is registered through a two-stage synchroniser before any logic looks at it. The address and write data travel through a matching two-stage delay, so they stay aligned with the strobes. The slave then detects the start of each synchronised access and performs exactly one action on it. For a write, it commits the data to the addressed register. For a read, it latches the addressed register into an output holding register and enables the bus driver.

Eight 16-bit registers sit at the low addresses. The rest of the address space is empty. The external bus is split into data in, data out and output enable, for a pad ring to combine. All register contents are exported in parallel to internal logic.

Bus rules the host must keep:
- Address and write data are stable from before the strobe falls until after it rises.
- A read strobe stays low at least five internal cycles.
- A write strobe stays low at least two internal cycles.
- Accesses are separated by at least three idle internal cycles.

Top module: `regslave_top`

## Requirements
- R1: While reset is asserted and right after it, every register reads as zero on `regOut` and `busDataOe` is low.
- R2: A write targets register `busAddr` when `busAddr` is below 8. The write is an access with `busCsN` and `busWeN` both low. The register is unchanged after the second rising clock edge that follows the strobe's fall. It holds the new data on `regOut` after the third, which is within 4 internal cycles. Register i occupies bits `[16*i+15:16*i]` of `regOut`.
- R3: Addresses 8 to 15 are unmapped. A write there changes no register, and a read there returns 0x0000.
- R4: A read is an access with `busCsN` and `busReN` both low and `busWeN` high. `busDataOe` stays low through the second rising edge after the strobe's fall. It is high with the addressed register's value on `busDataOut` after the third edge.
- R5: `busDataOe` falls in the same cycle that either `busCsN` or `busReN` rises, without waiting for the synchroniser.
- R6: A read acts once per access. `busDataOut` keeps the value latched at the start of the access even if `busAddr` changes while the strobe is held low.
- R7: A write acts once per access. A change of `busDataIn` after the commit, inside the same long strobe, does not reach the register.
- R8: While `busDataOe` stays high, `busDataOut` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busCsN | input | 1 | Chip select from the host, active low, asynchronous |
| busReN | input | 1 | Read strobe, active low, asynchronous |
| busWeN | input | 1 | Write strobe, active low, asynchronous |
| busAddr | input | ADDR_W (4) | Register address |
| busDataIn | input | DATA_W (16) | Write data from the host |
| busDataOut | output | DATA_W (16) | Read data toward the host |
| busDataOe | output | 1 | Drive enable for the read data |
| regOut | output | NUM_REGS*DATA_W (128) | All register contents, register i at bits [16*i+15:16*i] |

## Verification
A wrong synchroniser depth or a bad edge detector shows as a register or output enable that changes one edge too early or too late. The bench compares `regOut` and `busDataOe` against its model on every clock, so such a fault is reported within a cycle of the strobe. A misdecoded address or a stale read latch shows at the next read-back. Every host access is read back, and reads repeat after unmapped writes, so a corrupted register appears at its following read. A read that relatches mid-access shows as `busDataOut` moving while the enable is still high.

// File: rtl/regslave_pkg.sv
package regslave_pkg;
  // bit positions of the synchronised, active-high control flags
  localparam int CTL_CS = 2;
  localparam int CTL_RE = 1;
  localparam int CTL_WE = 0;
  localparam int CTL_W  = 3;

  // one-cycle commands from control to datapath
  typedef struct packed {
    logic wrCommit;  // first cycle a synchronised write is seen
    logic rdLaunch;  // first cycle a synchronised read is seen
    logic rdHold;    // read in progress, output may be driven
  } slaveStrobes_t;
endpackage

// File: rtl/slave_ctrl.sv
module slave_ctrl
  import regslave_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busCsN,
  input  logic          busReN,
  input  logic          busWeN,
  output slaveStrobes_t strobes
);
  logic [CTL_W-1:0] syncQ [SYNC_STAGES];
  logic [CTL_W-1:0] ctlSync;
  logic wrAct, rdAct, wrActQ, rdActQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= {~busCsN, ~busReN, ~busWeN};
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign ctlSync = syncQ[SYNC_STAGES-1];
  assign wrAct   = ctlSync[CTL_CS] & ctlSync[CTL_WE];
  assign rdAct   = ctlSync[CTL_CS] & ctlSync[CTL_RE] & ~ctlSync[CTL_WE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActQ <= 1'b0;
      rdActQ <= 1'b0;
    end else begin
      wrActQ <= wrAct;
      rdActQ <= rdAct;
    end
  end

  assign strobes.wrCommit = wrAct & ~wrActQ;
  assign strobes.rdLaunch = rdAct & ~rdActQ;
  assign strobes.rdHold   = rdActQ;
endmodule

// File: rtl/slave_dpath.sv
module slave_dpath
  import regslave_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int NUM_REGS    = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  slaveStrobes_t              strobes,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busDataIn,
  output logic [DATA_W-1:0]          rdDataOut,
  output logic [NUM_REGS*DATA_W-1:0] regFlat
);
  logic [ADDR_W-1:0] addrPipe [SYNC_STAGES];
  logic [DATA_W-1:0] dataPipe [SYNC_STAGES];
  logic [ADDR_W-1:0] addrAl;
  logic [DATA_W-1:0] dataAl;
  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic [DATA_W-1:0] rdMux, rdDataQ;

  // delay address and data exactly as far as the strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) begin
        addrPipe[s] <= '0;
        dataPipe[s] <= '0;
      end
    end else begin
      addrPipe[0] <= busAddr;
      dataPipe[0] <= busDataIn;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        addrPipe[s] <= addrPipe[s-1];
        dataPipe[s] <= dataPipe[s-1];
      end
    end
  end

  assign addrAl = addrPipe[SYNC_STAGES-1];
  assign dataAl = dataPipe[SYNC_STAGES-1];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gRegs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regQ[g] <= '0;
      else if (strobes.wrCommit && addrAl == ADDR_W'(g))
        regQ[g] <= dataAl;
    end
    assign regFlat[g*DATA_W +: DATA_W] = regQ[g];
  end

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addrAl == ADDR_W'(i)) rdMux = regQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rdDataQ <= '0;
    else if (strobes.rdLaunch) rdDataQ <= rdMux;
  end

  assign rdDataOut = rdDataQ;
endmodule

// File: rtl/regslave_top.sv
module regslave_top
  import regslave_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busCsN,
  input  logic                       busReN,
  input  logic                       busWeN,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busDataIn,
  output logic [DATA_W-1:0]          busDataOut,
  output logic                       busDataOe,
  output logic [NUM_REGS*DATA_W-1:0] regOut
);
  localparam int SYNC_STAGES = 2;

  slaveStrobes_t strobes;

  slave_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .busCsN(busCsN), .busReN(busReN), .busWeN(busWeN),
    .strobes(strobes)
  );

  slave_dpath #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .busAddr(busAddr), .busDataIn(busDataIn),
    .rdDataOut(busDataOut), .regFlat(regOut)
  );

  // the drive enable is cut directly by the raw strobes, so release is immediate
  assign busDataOe = strobes.rdHold & ~busCsN & ~busReN;
endmodule

// File: rtl/regslave_chk.sv
module regslave_chk #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       busCsN,
  input logic                       busReN,
  input logic                       busWeN,
  input logic [DATA_W-1:0]          busDataOut,
  input logic                       busDataOe,
  input logic [NUM_REGS*DATA_W-1:0] regOut
);
  // R5
  oe_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busCsN || busReN) |-> !busDataOe);

  // R2
  wr_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regOut) |-> $past(!busCsN && !busWeN, 2));

  // R4
  oe_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busDataOe) |-> $past(!busCsN && !busReN, 2));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busDataOe && $past(busDataOe)) |-> $stable(busDataOut));
endmodule

bind regslave_top regslave_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) uChk (
  .clk(clk), .rstN(rstN), .busCsN(busCsN), .busReN(busReN), .busWeN(busWeN),
  .busDataOut(busDataOut), .busDataOe(busDataOe), .regOut(regOut)
);

// File: tb/sim_regslave_top.sv
`timescale 1ns/1ps
module sim_regslave_top;
  localparam int DW = 16;
  localparam int NR = 8;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busCsN = 1'b1, busReN = 1'b1, busWeN = 1'b1;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busDataIn = '0;
  logic [DW-1:0] busDataOut;
  logic busDataOe;
  logic [NR*DW-1:0] regOut;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [NR];
  bit expOe = 1'b0;
  bit compareOn = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  regslave_top #(.DATA_W(DW), .NUM_REGS(NR), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .busCsN(busCsN), .busReN(busReN), .busWeN(busWeN),
    .busAddr(busAddr), .busDataIn(busDataIn), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .regOut(regOut)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic randPhase();
    real p;
    p = $urandom_range(300, 3400) / 1000.0;
    #(p);
  endtask

  // per-clock comparison against the model: R2 R3 R7 contents, R4 R5 enable
  always @(negedge clk) begin
    if (compareOn) begin
      for (int i = 0; i < NR; i++)
        check("R2 regOut vs model", regOut[i*DW +: DW], model[i]);
      check("R4 oe vs model", {15'b0, busDataOe}, {15'b0, expOe});
    end
  end

  task automatic doWrite(input int addr, input logic [DW-1:0] data, input int lowCycles,
                         input bit lateChange);
    @(posedge clk); randPhase();
    busAddr = AW'(addr); busDataIn = data;
    #0.1; busCsN = 1'b0; busWeN = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    if (addr < NR) check("R2 not before third edge", regOut[addr*DW +: DW], model[addr]);
    @(posedge clk); #1;
    if (addr < NR) begin
      model[addr] = data;
      check("R2 write landed", regOut[addr*DW +: DW], data);
    end
    for (int c = 3; c < lowCycles; c++) begin
      @(posedge clk);
      if (lateChange && c == 4) busDataIn = ~data;   // R7 stimulus
    end
    #1;
    if (lateChange && addr < NR) check("R7 late data ignored", regOut[addr*DW +: DW], data);
    randPhase();
    busWeN = 1'b1; busCsN = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic doRead(input int addr, input int lowCycles, input bit moveAddr,
                        input bit csFirst);
    logic [DW-1:0] exp;
    exp = (addr < NR) ? model[addr] : '0;
    @(posedge clk); randPhase();
    busAddr = AW'(addr);
    #0.1; busCsN = 1'b0; busReN = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    check("R4 oe low before third edge", {15'b0, busDataOe}, 16'h0);
    @(posedge clk); #1;
    expOe = 1'b1;
    check("R4 oe high by third edge", {15'b0, busDataOe}, 16'h1);
    if (addr < NR) check("R4 read data", busDataOut, exp);
    else           check("R3 unmapped reads zero", busDataOut, exp);
    if (moveAddr) busAddr = AW'((addr + 3) % NR);   // R6 stimulus
    for (int c = 3; c < lowCycles; c++) @(posedge clk);
    #1;
    if (moveAddr) check("R6 data held through access", busDataOut, exp);
    randPhase();
    if (csFirst) busCsN = 1'b1; else busReN = 1'b1;
    expOe = 1'b0;
    #0.2;
    check("R5 oe drops at release", {15'b0, busDataOe}, 16'h0);
    #0.2;
    busCsN = 1'b1; busReN = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < NR; i++) check("R1 reset value", regOut[i*DW +: DW], 16'h0);
    check("R1 oe low in reset", {15'b0, busDataOe}, 16'h0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 regs zero after reset", regOut[15:0], 16'h0);
    compareOn = 1'b1;

    // every mapped register, then read back
    for (int a = 0; a < NR; a++) doWrite(a, 16'h1000 * a[3:0] + 16'h0A5 + a[15:0], 2 + a % 3, 1'b0);
    for (int a = 0; a < NR; a++) doRead(a, 5 + a % 4, 1'b0, a[0]);

    // R3: unmapped writes leave the file untouched, unmapped reads give zero
    doWrite(9, 16'hDEAD, 4, 1'b0);
    doWrite(15, 16'hBEEF, 3, 1'b0);
    for (int a = 0; a < NR; a++) doRead(a, 5, 1'b0, 1'b0);
    doRead(12, 6, 1'b0, 1'b1);

    // R7: long write strobe with data changing after commit
    doWrite(5, 16'h5A5A, 10, 1'b1);
    doRead(5, 5, 1'b0, 1'b0);

    // R6: long read strobe with the address moving
    doRead(2, 12, 1'b1, 1'b0);

    // mixed traffic with random phase and lengths
    for (int n = 0; n < 80; n++) begin
      int a;
      a = $urandom_range(0, 15);
      if ($urandom_range(0, 1) == 1) doWrite(a, 16'($urandom()), $urandom_range(2, 9), 1'b0);
      else doRead(a, $urandom_range(5, 10), $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end

    compareOn = 1'b0;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule